// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block controls the switched supply of up to three downstream ports of a bus hub. For each port it drives an active-low enable pin toward an external power switch. It also watches the active-low overcurrent flag that the switch returns. The host's port commands reach the block as single-cycle power-on and power-off pulses. The block reports a per-port fault flag, which the surrounding hub logic sends back to the host.

Two static strap inputs set how the block behaves. The gang strap chooses between one shared supply for all ports and an independent supply for each port. The port-count strap chooses between a two-port build and a three-port build. Each raw overcurrent pin passes through a two-flop synchronizer and then a run-length filter, so short spikes on the flag never count as faults. A port that has been tripped stays off and keeps its fault flag set until the host powers it on again. The straps are read as static levels, and they are changed only while reset is held.

Top module: `hub_port_pwr_ctrl`

## Requirements
- R1: While reset is low (synchronous), and on the first edge after it is applied, every bit of `pwr_en_n_o` goes to 1 (power off) and every bit of `fault_o` goes to 0.
- R2: The enable outputs are active low. A power-on pulse for an active port drives its `pwr_en_n_o` bit to 0 on the next edge. A power-off pulse drives it back to 1. When on and off reach the same port in the same cycle, off wins.
- R3: An overcurrent pin (active low, 0 = fault) raises a fault only after it has been 0 on FILT_CYCLES consecutive clock edges (default 16). A run one sample shorter does nothing. A single high sample restarts the count. When the pin is sampled low on edges k to k+15, the output changes on edge k+18.
- R4: When an overcurrent is declared on a powered port, that port's `pwr_en_n_o` bit goes to 1 and its `fault_o` bit goes to 1.
- R5: With the gang strap low, each request and each overcurrent pin acts only on its own port. The other ports keep their state.
- R6: With the gang strap high, a request on any active port acts on all active ports. An overcurrent on any active port faults all active ports. The enable outputs of the active ports are always equal.
- R7: A faulted port stays unpowered, with its flag set, and a power-off pulse does not change that. Only a power-on pulse clears the flag and powers the port again.
- R8: With the port-count strap high, only ports 1 and 2 (bits 0 and 1) are active. Port 3 (bit 2) keeps `pwr_en_n_o` at 1 and `fault_o` at 0. Its requests and its overcurrent pin have no effect, and this holds in ganged mode as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gang_mode_i | input | 1 | Strap: 1 = shared supply for all ports, 0 = per-port supply |
| two_port_i | input | 1 | Strap: 1 = two-port build, 0 = three-port build |
| pwr_on_req_i | input | NUM_PORTS | Host power-on pulse, one bit per port |
| pwr_off_req_i | input | NUM_PORTS | Host power-off pulse, one bit per port |
| oc_n_i | input | NUM_PORTS | Raw overcurrent flags from the switches, active low |
| pwr_en_n_o | output | NUM_PORTS | Power-switch enables, active low |
| fault_o | output | NUM_PORTS | Latched overcurrent fault per port |

## Verification
The filter is driven with runs of low samples of 15 and 16 cycles, and with two 10-cycle runs split by one high sample. Together these pin the threshold to an exact count and show that the count restarts rather than adding up. The exact cycle of the trip is checked as well, which fixes the synchronizer and filter latency. The same trip and request patterns are repeated in per-port mode, in ganged mode and in two-port builds. This separates faults and commands that stay on one port from those that spread to all ports, and it shows that a disabled third port ignores both its pin and its commands. Simultaneous on/off pulses and off pulses sent to a faulted port check the command priority and the fault hold.

// File: rtl/hub_pwr_pkg.sv
// Package: shared types for the hub port power controller.
// Assumes: one command record per port, built fresh every cycle by the router.
package hub_pwr_pkg;

    // Per-port command seen by a port slot in one cycle
    typedef struct packed {
        logic enable;   // port is part of the active build
        logic oc_hit;   // filtered overcurrent routed to this port
        logic off_req;  // power-off command routed to this port
        logic on_req;   // power-on command routed to this port
    } slot_cmd_t;

endpackage

// File: rtl/hub_oc_filter.sv
// Module: hub_oc_filter
// Synchronizes one raw active-low overcurrent pin and declares a fault
// once the pin has been low for FILT_CYCLES consecutive samples.
// Assumes: SYNC_STAGES >= 2, FILT_CYCLES >= 1; det_o holds while the count
// is saturated and drops once a high sample reaches the counter.
module hub_oc_filter #(
    parameter int FILT_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n_i,
    output logic det_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   sync_low;

    // Bring the asynchronous pin into the clock domain, idle level high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], oc_n_i};
    end

    assign sync_low = !sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturate at the limit, clear on high
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= '0;
        else if (!sync_low)        run_q <= '0;
        else if (run_q != LIMIT)   run_q <= run_q + 1'b1;
    end

    assign det_o = (run_q == LIMIT);

    // R3: a detection can only begin right after a low sample
    p_trip_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_o) |-> $past(sync_low));

    // R3: a high sample always removes the detection on the next cycle
    p_high_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_low |=> !det_o);

endmodule

// File: rtl/hub_pwr_route.sv
// Module: hub_pwr_route
// Combinational routing of host requests and filtered overcurrents to the
// port slots according to the gang and port-count straps.
// Assumes: straps are static outside reset; the last port is the one
// dropped in the reduced build.
module hub_pwr_route
    import hub_pwr_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                  gang_mode_i,
    input  logic                  two_port_i,
    input  logic [NUM_PORTS-1:0]  on_req_i,
    input  logic [NUM_PORTS-1:0]  off_req_i,
    input  logic [NUM_PORTS-1:0]  det_i,
    output slot_cmd_t [NUM_PORTS-1:0] cmd_o
);
    logic [NUM_PORTS-1:0] active;
    logic                 any_on, any_off, any_det;

    // Work out which ports exist in this build
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_active
        if (i < NUM_PORTS - 1) begin : g_fixed
            assign active[i] = 1'b1;
        end else begin : g_strap
            assign active[i] = !two_port_i;
        end
    end

    // Ganged sources, only from active ports
    always_comb begin
        any_on  = |(on_req_i  & active);
        any_off = |(off_req_i & active);
        any_det = |(det_i     & active);
    end

    // Per-port command: shared sources in ganged mode, own sources otherwise
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_cmd
        always_comb begin
            cmd_o[i].enable  = active[i];
            cmd_o[i].on_req  = active[i] & (gang_mode_i ? any_on  : on_req_i[i]);
            cmd_o[i].off_req = active[i] & (gang_mode_i ? any_off : off_req_i[i]);
            cmd_o[i].oc_hit  = active[i] & (gang_mode_i ? any_det : det_i[i]);
        end
    end

endmodule

// File: rtl/hub_port_slot.sv
// Module: hub_port_slot
// State of one downstream port: powered flag and latched fault flag.
// Priority: disabled port > overcurrent > power-off > power-on.
// Assumes: commands arrive already gated by the router.
module hub_port_slot
    import hub_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_cmd_t cmd_i,
    output logic      pwr_en_n_o,
    output logic      fault_o
);
    logic powered_q, fault_q;

    // Update power and fault state from the routed command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            powered_q <= 1'b0;
            fault_q   <= 1'b0;
        end else if (!cmd_i.enable) begin
            powered_q <= 1'b0;
            fault_q   <= 1'b0;
        end else if (cmd_i.oc_hit) begin
            powered_q <= 1'b0;
            fault_q   <= 1'b1;
        end else if (cmd_i.off_req) begin
            powered_q <= 1'b0;
        end else if (cmd_i.on_req) begin
            powered_q <= 1'b1;
            fault_q   <= 1'b0;
        end
    end

    assign pwr_en_n_o = !powered_q;
    assign fault_o    = fault_q;

    // R7: a faulted port is never powered
    p_fault_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> pwr_en_n_o);

    // R4: a routed overcurrent removes power and sets the flag
    p_oc_trips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.enable && cmd_i.oc_hit) |=> (fault_o && pwr_en_n_o));

    // R2: an off command beats a same-cycle on command
    p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.enable && !cmd_i.oc_hit && cmd_i.off_req) |=> pwr_en_n_o);

    // R8: a port outside the build stays off and clean
    p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i.enable |=> (pwr_en_n_o && !fault_o));

endmodule

// File: rtl/hub_port_pwr_ctrl.sv
// Module: hub_port_pwr_ctrl (top)
// Downstream port power controller: one overcurrent filter per port, a
// strap-driven router, and one state slot per port.
// Assumes: straps change only during reset; requests are one-cycle pulses.
module hub_port_pwr_ctrl
    import hub_pwr_pkg::*;
#(
    parameter int NUM_PORTS   = 3,
    parameter int FILT_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gang_mode_i,
    input  logic                 two_port_i,
    input  logic [NUM_PORTS-1:0] pwr_on_req_i,
    input  logic [NUM_PORTS-1:0] pwr_off_req_i,
    input  logic [NUM_PORTS-1:0] oc_n_i,
    output logic [NUM_PORTS-1:0] pwr_en_n_o,
    output logic [NUM_PORTS-1:0] fault_o
);
    logic [NUM_PORTS-1:0]      det;
    slot_cmd_t [NUM_PORTS-1:0] cmd;

    // One glitch filter per overcurrent pin
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_filt
        hub_oc_filter #(
            .FILT_CYCLES (FILT_CYCLES),
            .SYNC_STAGES (SYNC_STAGES)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .oc_n_i (oc_n_i[i]),
            .det_o  (det[i])
        );
    end

    hub_pwr_route #(
        .NUM_PORTS (NUM_PORTS)
    ) route_i (
        .gang_mode_i (gang_mode_i),
        .two_port_i  (two_port_i),
        .on_req_i    (pwr_on_req_i),
        .off_req_i   (pwr_off_req_i),
        .det_i       (det),
        .cmd_o       (cmd)
    );

    // One state slot per port
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
        hub_port_slot slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_i      (cmd[i]),
            .pwr_en_n_o (pwr_en_n_o[i]),
            .fault_o    (fault_o[i])
        );
    end

    // R6: in ganged mode every active port matches port 1
    for (genvar i = 1; i < NUM_PORTS; i++) begin : g_gang_chk
        p_gang_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (gang_mode_i && (!two_port_i || (i < NUM_PORTS - 1)))
                |-> (pwr_en_n_o[i] == pwr_en_n_o[0] && fault_o[i] == fault_o[0]));
    end

    // R8: the dropped port of a reduced build stays off
    p_unused_port_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (two_port_i && $past(two_port_i)) |-> (pwr_en_n_o[NUM_PORTS-1] && !fault_o[NUM_PORTS-1]));

endmodule

// File: tb/hub_port_pwr_ctrl_tb_top.sv
// Directed bench for hub_port_pwr_ctrl: one task per scenario.
module hub_port_pwr_ctrl_tb_top;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gang = 1'b0;
    logic         two_port = 1'b0;
    logic [N-1:0] on_req = '0;
    logic [N-1:0] off_req = '0;
    logic [N-1:0] oc_n = '1;
    logic [N-1:0] pwr_en_n;
    logic [N-1:0] fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hub_port_pwr_ctrl #(.NUM_PORTS(N), .FILT_CYCLES(16), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .gang_mode_i   (gang),
        .two_port_i    (two_port),
        .pwr_on_req_i  (on_req),
        .pwr_off_req_i (off_req),
        .oc_n_i        (oc_n),
        .pwr_en_n_o    (pwr_en_n),
        .fault_o       (fault)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic g, input logic tp);
        rst_n = 1'b0; gang = g; two_port = tp;
        on_req = '0; off_req = '0; oc_n = '1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic pulse(input logic [N-1:0] on_m, input logic [N-1:0] off_m);
        on_req = on_m; off_req = off_m;
        idle(1);
        on_req = '0; off_req = '0;
    endtask

    // pin low for n edges, released, then three edges for the trip to land
    task automatic hold_oc(input logic [N-1:0] m, input int n);
        oc_n = ~m;
        idle(n);
        oc_n = '1;
        idle(3);
    endtask

    task automatic t_reset_values();
        do_reset(1'b0, 1'b0);
        chk("R1 enables after reset", pwr_en_n, 3'b111);
        chk("R1 faults after reset", fault, 3'b000);
        pulse(3'b111, 3'b000);
        chk("R1 precondition powered", pwr_en_n, 3'b000);
        rst_n = 1'b0;
        idle(1);
        chk("R1 enables in reset", pwr_en_n, 3'b111);
        chk("R1 faults in reset", fault, 3'b000);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_perport_switching();
        do_reset(1'b0, 1'b0);
        pulse(3'b001, 3'b000);
        chk("R2 R5 on port1 only", pwr_en_n, 3'b110);
        pulse(3'b100, 3'b000);
        chk("R2 R5 on port3 only", pwr_en_n, 3'b010);
        pulse(3'b000, 3'b001);
        chk("R2 R5 off port1 only", pwr_en_n, 3'b011);
        pulse(3'b010, 3'b010);
        chk("R2 off wins over on", pwr_en_n, 3'b011);
    endtask

    task automatic t_filter_glitch();
        do_reset(1'b0, 1'b0);
        pulse(3'b111, 3'b000);
        hold_oc(3'b010, 15);
        chk("R3 15-cycle low ignored enables", pwr_en_n, 3'b000);
        chk("R3 15-cycle low ignored faults", fault, 3'b000);
        oc_n = 3'b101;
        idle(10);
        oc_n = 3'b111;
        idle(1);
        hold_oc(3'b010, 10);
        chk("R3 split run restarts count", fault, 3'b000);
        chk("R3 split run keeps power", pwr_en_n, 3'b000);
    endtask

    task automatic t_filter_trip();
        do_reset(1'b0, 1'b0);
        pulse(3'b111, 3'b000);
        oc_n = 3'b101;
        idle(16);
        oc_n = 3'b111;
        idle(2);
        chk("R3 no trip before latency", pwr_en_n, 3'b000);
        idle(1);
        chk("R3 R4 R5 trip only port2", pwr_en_n, 3'b010);
        chk("R4 R5 fault only port2", fault, 3'b010);
    endtask

    task automatic t_fault_hold();
        pulse(3'b000, 3'b010);
        chk("R7 off keeps fault flag", fault, 3'b010);
        idle(5);
        chk("R7 port stays unpowered", pwr_en_n, 3'b010);
        pulse(3'b010, 3'b000);
        chk("R7 on clears fault", fault, 3'b000);
        chk("R7 on restores power", pwr_en_n, 3'b000);
    endtask

    task automatic t_ganged();
        do_reset(1'b1, 1'b0);
        pulse(3'b100, 3'b000);
        chk("R6 one on powers all", pwr_en_n, 3'b000);
        pulse(3'b000, 3'b001);
        chk("R6 one off removes all", pwr_en_n, 3'b111);
        pulse(3'b010, 3'b000);
        hold_oc(3'b001, 16);
        chk("R6 one overcurrent trips all", pwr_en_n, 3'b111);
        chk("R6 all flags set", fault, 3'b111);
        pulse(3'b100, 3'b000);
        chk("R6 R7 one on clears all flags", fault, 3'b000);
        chk("R6 R7 one on repowers all", pwr_en_n, 3'b000);
    endtask

    task automatic t_two_port();
        do_reset(1'b0, 1'b1);
        pulse(3'b111, 3'b000);
        chk("R8 port3 stays off", pwr_en_n, 3'b100);
        hold_oc(3'b100, 20);
        chk("R8 port3 overcurrent ignored faults", fault, 3'b000);
        chk("R8 port3 overcurrent ignored enables", pwr_en_n, 3'b100);
        do_reset(1'b1, 1'b1);
        pulse(3'b100, 3'b000);
        chk("R8 ganged request from port3 ignored", pwr_en_n, 3'b111);
        pulse(3'b001, 3'b000);
        chk("R6 R8 ganged on reaches ports 1-2 only", pwr_en_n, 3'b100);
        hold_oc(3'b100, 20);
        chk("R8 ganged port3 overcurrent ignored", fault, 3'b000);
        hold_oc(3'b010, 16);
        chk("R6 R8 ganged trip spares port3 flag", fault, 3'b011);
        chk("R6 R8 ganged trip enables", pwr_en_n, 3'b111);
    endtask

    initial begin
        idle(1);
        t_reset_values();
        t_perport_switching();
        t_filter_glitch();
        t_filter_trip();
        t_fault_hold();
        t_ganged();
        t_two_port();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule